// File: doc/BRIEF.md
# Mirrored Byte-Count Table Writer

The block holds one table of 16-bit frame byte counts for each transmit queue. A transmit scheduler reads these tables. Each table has 256 primary slots, one per descriptor, and a 64-slot tail placed after the primary region. The tail always repeats the first 64 primary slots. A reader can therefore take any window of up to 64 consecutive entries from any starting descriptor, using a plain addition and no modulo arithmetic.

On the write side a producer offers a queue number, a descriptor index and a byte count, using a valid/ready handshake. The producer sees no difference between two kinds of write. A write to one of the first 64 descriptors is stored in its primary slot. In the following cycle the same value is stored in the tail slot at the same offset, and the block holds ready low during that cycle. An index of 256 or more is not a descriptor: the block discards it and pulses an error flag.

On the read side the scheduler gives a queue, a window base (0–255) and an offset (0–63). One cycle later it receives the entry at base plus offset. If a write lands on that same entry at the same clock edge, the read returns the new value. In the host memory map each queue's table occupies a 1024-byte stride. The 640 bytes of data sit at the start of the stride.

Top module: `bct_writer`

## Requirements
- R1: Out of reset, wr_ready is 1, wr_err is 0 and rd_valid is 0.
- R2: An accepted write with index 64–255 stores the count in that primary slot only, and wr_ready stays 1 in the next cycle.
- R3: An accepted write with index 0–63 stores the count both in slot index and in slot index+256 of the same queue.
- R4: After a write with index 0–63 is accepted, wr_ready is 0 for exactly one cycle and then returns to 1. A write offered while wr_ready is 0 is not taken, and stays pending until accepted.
- R5: An accepted write with index 256–511 changes no slot. wr_err is 1 in the cycle after that write and 0 in every other cycle.
- R6: rd_valid is 1 exactly in the cycle after rd_en. rd_data then holds the slot base+offset of the chosen queue, with no wrap. For example, base 250 with offset 20 returns slot 270, which mirrors slot 14.
- R7: A read whose slot is written at the same clock edge returns the newly written value. This covers both a primary write and the delayed tail copy.
- R8: Writes to one queue leave every slot of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write offer |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_queue | input | 4 | Target queue of the write |
| wr_index | input | 9 | Descriptor index; 256 and above is rejected |
| wr_bytes | input | 16 | Byte count to store |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| rd_en | input | 1 | Read request |
| rd_queue | input | 4 | Queue to read |
| rd_base | input | 8 | Window base descriptor |
| rd_off | input | 6 | Offset inside the window |
| rd_valid | output | 1 | rd_data holds the requested entry |
| rd_data | output | 16 | Entry read |

## Verification
The main internal hazard is a stale or misplaced tail copy. It does not show up when the write happens. It shows up later, when a window read crosses past slot 255 and returns an old value, a value from another queue, or a value from the wrong offset. For this reason the reference model is compared on every read, and the random traffic mixes low-index writes with window reads that wrap.

A wrong pending-copy state appears at wr_ready in the very next cycle, either as a missing stall or as an extra stall. A wrong bypass decision appears in the read result one cycle after the colliding edge.

// File: rtl/bct_pkg.sv
package bct_pkg;

  localparam int unsigned NQ_DEF   = 16;
  localparam int unsigned PRIM_DEF = 256;
  localparam int unsigned WIN_DEF  = 64;
  localparam int unsigned DW_DEF   = 16;

  // which copy the single storage write port carries this cycle
  typedef enum logic [1:0] {
    WSRC_IDLE    = 2'd0,
    WSRC_PRIMARY = 2'd1,
    WSRC_MIRROR  = 2'd2
  } wsrc_e;

endpackage

// File: rtl/bct_wr_seq.sv
module bct_wr_seq
  import bct_pkg::*;
#(
  parameter int unsigned QW   = 4,
  parameter int unsigned IW   = 9,
  parameter int unsigned DW   = 16,
  parameter int unsigned PRIM = 256,
  parameter int unsigned WIN  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [QW-1:0] wr_queue,
  input  logic [IW-1:0] wr_index,
  input  logic [DW-1:0] wr_bytes,
  output logic          wr_err,
  output logic          st_we,
  output logic [QW-1:0] st_q,
  output logic [IW-1:0] st_idx,
  output logic [DW-1:0] st_data
);

  localparam int unsigned OW = $clog2(WIN);
  localparam logic [IW-1:0] PRIM_I = IW'(PRIM);
  localparam logic [IW-1:0] WIN_I  = IW'(WIN);

  logic          pend_r, pend_nxt;
  logic          err_r, err_nxt;
  logic [QW-1:0] pend_q;
  logic [OW-1:0] pend_off;
  logic [DW-1:0] pend_dat;
  logic          accept, in_prim, in_low, load_en;
  wsrc_e         src;

  // next-state and write-port steering
  always_comb begin
    accept   = wr_valid & ~pend_r;
    in_prim  = wr_index < PRIM_I;
    in_low   = wr_index < WIN_I;
    pend_nxt = accept & in_low;
    err_nxt  = accept & ~in_prim;
    load_en  = pend_nxt;

    if (pend_r)                 src = WSRC_MIRROR;
    else if (accept && in_prim) src = WSRC_PRIMARY;
    else                        src = WSRC_IDLE;

    st_we   = 1'b0;
    st_q    = wr_queue;
    st_idx  = wr_index;
    st_data = wr_bytes;
    unique case (src)
      WSRC_MIRROR: begin
        st_we   = 1'b1;
        st_q    = pend_q;
        st_idx  = PRIM_I + IW'(pend_off);
        st_data = pend_dat;
      end
      WSRC_PRIMARY: st_we = 1'b1;
      default:      st_we = 1'b0;
    endcase
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_r <= 1'b0;
      err_r  <= 1'b0;
    end else begin
      pend_r <= pend_nxt;
      err_r  <= err_nxt;
    end
  end

  // captured copy for the tail slot, clock-enabled
  always_ff @(posedge clk) begin
    if (load_en) begin
      pend_q   <= wr_queue;
      pend_off <= wr_index[OW-1:0];
      pend_dat <= wr_bytes;
    end
  end

  assign wr_ready = ~pend_r;
  assign wr_err   = err_r;

endmodule

// File: rtl/bct_win_addr.sv
module bct_win_addr #(
  parameter int unsigned BW = 8,
  parameter int unsigned OW = 6,
  parameter int unsigned IW = 9
) (
  input  logic [BW-1:0] base,
  input  logic [OW-1:0] off,
  output logic [IW-1:0] idx
);

  // straight sum: the mirrored tail makes any base+offset a valid slot
  always_comb begin
    idx = IW'(base) + IW'(off);
  end

endmodule

// File: rtl/bct_banks.sv
module bct_banks #(
  parameter int unsigned NQ  = 16,
  parameter int unsigned TBL = 320,
  parameter int unsigned DW  = 16,
  parameter int unsigned QW  = 4,
  parameter int unsigned IW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [QW-1:0] wq,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [QW-1:0] rq,
  input  logic [IW-1:0] ridx,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] bank_rd [NQ];
  logic          hit;
  logic [DW-1:0] rd_nxt;

  for (genvar g = 0; g < NQ; g++) begin : g_bank
    logic [DW-1:0] mem [TBL];
    logic          bank_we;

    assign bank_we    = we && (wq == QW'(g));
    assign bank_rd[g] = mem[ridx];

    always_ff @(posedge clk) begin
      if (bank_we) mem[widx] <= wdata;
    end
  end

  // write-first bypass for a read colliding with the edge's write
  always_comb begin
    hit    = we && (wq == rq) && (widx == ridx);
    rd_nxt = hit ? wdata : bank_rd[rq];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_nxt;
    end
  end

endmodule

// File: rtl/bct_writer.sv
module bct_writer
  import bct_pkg::*;
#(
  parameter int unsigned NQ   = NQ_DEF,
  parameter int unsigned PRIM = PRIM_DEF,
  parameter int unsigned WIN  = WIN_DEF,
  parameter int unsigned DW   = DW_DEF,
  localparam int unsigned TBL = PRIM + WIN,
  localparam int unsigned QW  = $clog2(NQ),
  localparam int unsigned IW  = $clog2(TBL),
  localparam int unsigned BW  = $clog2(PRIM),
  localparam int unsigned OW  = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [QW-1:0] wr_queue,
  input  logic [IW-1:0] wr_index,
  input  logic [DW-1:0] wr_bytes,
  output logic          wr_err,
  input  logic          rd_en,
  input  logic [QW-1:0] rd_queue,
  input  logic [BW-1:0] rd_base,
  input  logic [OW-1:0] rd_off,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic          st_we;
  logic [QW-1:0] st_q;
  logic [IW-1:0] st_idx;
  logic [DW-1:0] st_data;
  logic [IW-1:0] rd_idx;

  bct_wr_seq #(
    .QW(QW), .IW(IW), .DW(DW), .PRIM(PRIM), .WIN(WIN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_queue (wr_queue),
    .wr_index (wr_index),
    .wr_bytes (wr_bytes),
    .wr_err   (wr_err),
    .st_we    (st_we),
    .st_q     (st_q),
    .st_idx   (st_idx),
    .st_data  (st_data)
  );

  bct_win_addr #(
    .BW(BW), .OW(OW), .IW(IW)
  ) u_addr (
    .base (rd_base),
    .off  (rd_off),
    .idx  (rd_idx)
  );

  bct_banks #(
    .NQ(NQ), .TBL(TBL), .DW(DW), .QW(QW), .IW(IW)
  ) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (st_we),
    .wq       (st_q),
    .widx     (st_idx),
    .wdata    (st_data),
    .rd_en    (rd_en),
    .rq       (rd_queue),
    .ridx     (rd_idx),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/bct_chk.sv
module bct_chk #(
  parameter int unsigned IW   = 9,
  parameter int unsigned PRIM = 256,
  parameter int unsigned WIN  = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [IW-1:0] wr_index,
  input logic          wr_err,
  input logic          rd_en,
  input logic          rd_valid
);

  localparam logic [IW-1:0] PRIM_I = IW'(PRIM);
  localparam logic [IW-1:0] WIN_I  = IW'(WIN);

  logic acc;
  assign acc = wr_valid && wr_ready;

  // R4
  mirror_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_index < WIN_I) |=> !wr_ready);

  // R4
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> wr_ready);

  // R2
  plain_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_index >= WIN_I) |=> wr_ready);

  // R5
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_index >= PRIM_I) |=> wr_err);

  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && wr_index >= PRIM_I) |=> !wr_err);

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R6
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

endmodule

bind bct_writer bct_chk #(.IW(IW), .PRIM(PRIM), .WIN(WIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_index (wr_index),
  .wr_err   (wr_err),
  .rd_en    (rd_en),
  .rd_valid (rd_valid)
);

// File: tb/bct_writer_bench.sv
`timescale 1ns/1ps
module bct_writer_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [3:0]  wr_queue;
  logic [8:0]  wr_index;
  logic [15:0] wr_bytes;
  logic        wr_err;
  logic        rd_en;
  logic [3:0]  rd_queue;
  logic [7:0]  rd_base;
  logic [5:0]  rd_off;
  logic        rd_valid;
  logic [15:0] rd_data;

  int total;
  int fails;
  string cur_req;

  // reference model state
  int unsigned mdl [16][320];
  bit m_ready, m_pend, m_err, m_rv;
  int m_pq, m_pi, m_pd, m_rd;

  bct_writer u_bct_writer (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_queue(wr_queue),
    .wr_index(wr_index), .wr_bytes(wr_bytes), .wr_err(wr_err),
    .rd_en(rd_en), .rd_queue(rd_queue), .rd_base(rd_base), .rd_off(rd_off),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // model one clock edge from the inputs now applied, then compare
  task automatic tick();
    bit acc;
    acc = wr_valid && m_ready;
    if (m_pend) mdl[m_pq][256 + m_pi] = m_pd;
    if (acc && wr_index < 256) mdl[wr_queue][wr_index] = wr_bytes;
    m_rv = rd_en;
    if (rd_en) m_rd = mdl[rd_queue][int'(rd_base) + int'(rd_off)];
    m_err = acc && (wr_index >= 256);
    m_pend = acc && (wr_index < 64);
    if (m_pend) begin
      m_pq = wr_queue; m_pi = wr_index; m_pd = wr_bytes;
    end
    m_ready = !m_pend;
    @(negedge clk);
    chk("R4", wr_ready, m_ready);
    chk("R5", wr_err, m_err);
    chk("R6", rd_valid, m_rv);
    if (m_rv) chk(cur_req, rd_data, m_rd);
  endtask

  task automatic wr(int q, int i, int d);
    bit a;
    wr_valid = 1'b1; wr_queue = 4'(q); wr_index = 9'(i); wr_bytes = 16'(d);
    forever begin
      a = m_ready;
      tick();
      if (a) break;
    end
    wr_valid = 1'b0;
  endtask

  task automatic rd(int q, int b, int o);
    rd_en = 1'b1; rd_queue = 4'(q); rd_base = 8'(b); rd_off = 6'(o);
    tick();
    rd_en = 1'b0;
  endtask

  initial begin
    #(100000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    total = 0; fails = 0; cur_req = "R1";
    rst_n = 1'b0; wr_valid = 1'b0; wr_queue = '0; wr_index = '0; wr_bytes = '0;
    rd_en = 1'b0; rd_queue = '0; rd_base = '0; rd_off = '0;
    m_ready = 1; m_pend = 0; m_err = 0; m_rv = 0; m_pq = 0; m_pi = 0; m_pd = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", wr_ready, 1);
    chk("R1", wr_err, 0);
    chk("R1", rd_valid, 0);

    // fill every queue; low slots also build the tail (R3)
    cur_req = "R3";
    for (int q = 0; q < 16; q++)
      for (int i = 0; i < 256; i++)
        wr(q, i, (q * 37 + i * 13 + 5) & 16'hffff);

    // R3 tail copies visible through wrapping windows
    for (int q = 0; q < 16; q += 5) begin
      rd(q, 7, 0);
      rd(q, 255, 8);
      rd(q, 200, 63);
    end

    // R2 primary-only write, neighbour slot and tail untouched
    cur_req = "R2";
    wr(3, 100, 16'hbeef);
    rd(3, 100, 0);
    rd(3, 36, 0);
    rd(3, 255, 37);

    // R4 offer held through the stall with new data
    cur_req = "R4";
    wr_valid = 1'b1; wr_queue = 4'd2; wr_index = 9'd20; wr_bytes = 16'h1111;
    tick();
    wr_index = 9'd150; wr_bytes = 16'h2222;
    tick();
    tick();
    wr_valid = 1'b0;
    rd(2, 20, 0);
    rd(2, 250, 26);
    rd(2, 150, 0);

    // R5 rejected indexes leave slots alone
    cur_req = "R5";
    wr(2, 300, 16'hdead);
    rd(2, 250, 50);
    wr(2, 256, 16'hdead);
    rd(2, 255, 1);
    rd(2, 0, 0);

    // R6 wrapping window read
    cur_req = "R6";
    rd(9, 250, 20);
    rd(9, 14, 0);

    // R7 collisions: primary and delayed tail copy
    cur_req = "R7";
    wr_valid = 1'b1; wr_queue = 4'd6; wr_index = 9'd120; wr_bytes = 16'h7777;
    rd_en = 1'b1; rd_queue = 4'd6; rd_base = 8'd100; rd_off = 6'd20;
    tick();
    wr_valid = 1'b0; rd_en = 1'b0;
    wr_valid = 1'b1; wr_queue = 4'd6; wr_index = 9'd7; wr_bytes = 16'h5a5a;
    tick();
    wr_valid = 1'b0;
    rd_en = 1'b1; rd_queue = 4'd6; rd_base = 8'd255; rd_off = 6'd8;
    tick();
    rd_en = 1'b0;

    // R8 other queues unaffected by the above
    cur_req = "R8";
    rd(5, 7, 0);
    rd(7, 120, 0);
    rd(5, 255, 8);

    // mixed random traffic against the model
    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      wr_valid = ($urandom_range(0, 9) < 6);
      wr_queue = 4'($urandom_range(0, 15));
      wr_index = 9'($urandom_range(0, 300));
      wr_bytes = 16'($urandom);
      rd_en    = ($urandom_range(0, 1) == 1);
      rd_queue = 4'($urandom_range(0, 15));
      rd_base  = 8'($urandom_range(0, 255));
      rd_off   = 6'($urandom_range(0, 63));
      tick();
    end
    wr_valid = 1'b0; rd_en = 1'b0;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

endmodule